// File: doc/BRIEF.md
# Minute-Resolution Field-Masked Alarm Comparator

This block watches the running calendar time supplied by a timekeeping core and raises an alarm when that time agrees with a programmed alarm setting. The setting has four fields: minute, hour, day of month and day of week. Each field can be included in or left out of the comparison on its own, so software can request an alarm "every hour at minute 30", "every Tuesday at any time", or "on the 15th at 07:45". The match is made only on the strobe that starts a new minute, when the seconds value has just turned to 00. The block therefore resolves alarms to the minute, and fires at most once for a given matching minute.

Software reaches the block through a byte-wide register port with a write strobe and a combinational read. The port gives access to the four alarm registers, the alarm interrupt enable and the alarm status flag. The status flag stays set until software writes a zero to it. The interrupt request is a level output that is high while the flag and the enable are both set.

A three-state sequencer handles each minute boundary. The states are:
- ST_IDLE: waiting for a boundary.
- ST_CHECK: evaluating the comparison for one cycle.
- ST_HOLD: a hit was taken in the minute recorded at the hit.

The transitions are:
- T_BOUNDARY: ST_IDLE to ST_CHECK, on a strobe with seconds 00.
- T_HIT: ST_CHECK to ST_HOLD, which also sets the flag.
- T_MISS: ST_CHECK to ST_IDLE.
- T_REENTER: ST_HOLD to ST_CHECK, on a strobe with seconds 00 and a different minute.
- T_LEAVE: ST_HOLD to ST_IDLE, on a strobe with nonzero seconds.
- T_REPEAT: ST_HOLD back to ST_HOLD, on a strobe with seconds 00 and the same minute.

Top module: `minute_alarm_unit`

## Requirements
- R1: After reset, each alarm register reads 0x80 (field excluded), the addresses 0x00 and 0x01 read 0x00, and `alarm_irq` is low.
- R2: The alarm registers sit at these addresses: minute 0x0A, hour 0x0B, day of month 0x0C, day of week 0x0D. Bit 7 always stores. Minute stores bits 6:0. Hour and day of month store bits 5:0, and their bit 6 reads 0. Day of week stores bits 2:0, and its bits 6:3 read 0. Address 0x00 stores only the interrupt enable, in bit 1.
- R3: Bit 7 of an alarm register is an active-low field enable. A field with bit 7 at 0 must equal its time input for a hit. A field with bit 7 at 1 is ignored, whatever its value.
- R4: On the clock edge where `tick_sec` is 1 and `cur_sec` is 0x00, the sequencer captures a boundary. If at least one field is enabled and every enabled field matches, the status flag (address 0x01, bit 3) reads 1 after the following edge. A strobe with a nonzero `cur_sec` never sets the flag.
- R5: When all four fields are disabled, the flag is never set.
- R6: After a hit, a further seconds-00 strobe with the same minute value does not set the flag again. A strobe with nonzero seconds re-arms the sequencer.
- R7: Writing address 0x01 with bit 3 at 0 clears the flag. Writing it with bit 3 at 1 leaves the flag unchanged. A hit in the same cycle as a clear wins.
- R8: `alarm_irq` is high exactly while the flag and the enable (address 0x00, bit 1) are both 1. It stays high until one of them is cleared.
- R9: Writes to any other address have no effect, and reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sec | input | 1 | One-cycle strobe when the seconds value changes |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current day of week |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data (combinational) |
| alarm_irq | output | 1 | Level alarm interrupt request |

## Verification
The situation hardest to reach from the ports is ST_HOLD meeting a second seconds-00 strobe that carries the same minute. A real clock never produces this, because 59 nonzero strobes lie between two boundaries. The stimulus produces it directly. It fires an alarm, clears the flag through the bus, and then issues a bare seconds-00 strobe with unchanged time, expecting no new flag. It then sends one strobe with nonzero seconds and repeats the boundary, to show that the sequencer re-arms. Every other boundary in the bench is preceded by a nonzero-seconds strobe, so each field-mask case starts from ST_IDLE.

// File: rtl/mau_pkg.sv
package mau_pkg;

    localparam int unsigned FIELD_N      = 4;
    localparam int unsigned REG_CTRL_IE  = 'h00;
    localparam int unsigned REG_CTRL_ST  = 'h01;
    localparam int unsigned REG_ALM_BASE = 'h0A;
    localparam int unsigned IE_BIT       = 1;
    localparam int unsigned FLAG_BIT     = 3;
    localparam int unsigned EN_BIT       = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_HOLD  = 2'd2
    } seq_state_e;

    // significant value bits per field: 0 minute, 1 hour, 2 date, 3 weekday
    function automatic int unsigned field_width(int unsigned idx);
        case (idx)
            0:       return 7;
            1, 2:    return 6;
            default: return 3;
        endcase
    endfunction

    function automatic logic [6:0] field_mask(int unsigned idx);
        return 7'((32'd1 << field_width(idx)) - 32'd1);
    endfunction

endpackage

// File: rtl/mau_regs.sv
module mau_regs
    import mau_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    input  logic                            flag,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic [FIELD_N-1:0][DATA_W-1:0]  alm_cfg,
    output logic                            alarm_ie,
    output logic                            clr_req
);

    localparam logic [DATA_W-1:0] CFG_RESET = DATA_W'(1) << EN_BIT;

    for (genvar g = 0; g < FIELD_N; g++) begin : g_field
        localparam logic [DATA_W-1:0] KEEP = CFG_RESET | DATA_W'(field_mask(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                alm_cfg[g] <= CFG_RESET;
            end else if (bus_wr && bus_addr == ADDR_W'(REG_ALM_BASE + g)) begin
                alm_cfg[g] <= bus_wdata & KEEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_ie <= 1'b0;
        end else if (bus_wr && bus_addr == ADDR_W'(REG_CTRL_IE)) begin
            alarm_ie <= bus_wdata[IE_BIT];
        end
    end

    assign clr_req = bus_wr && (bus_addr == ADDR_W'(REG_CTRL_ST)) && !bus_wdata[FLAG_BIT];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_CTRL_IE)) begin
            bus_rdata[IE_BIT] = alarm_ie;
        end
        if (bus_addr == ADDR_W'(REG_CTRL_ST)) begin
            bus_rdata[FLAG_BIT] = flag;
        end
        for (int i = 0; i < FIELD_N; i++) begin
            if (bus_addr == ADDR_W'(REG_ALM_BASE + i)) begin
                bus_rdata = alm_cfg[i];
            end
        end
    end

endmodule

// File: rtl/mau_match.sv
module mau_match
    import mau_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [FIELD_N-1:0][DATA_W-1:0] alm_cfg,
    input  logic [6:0]                     cur_min,
    input  logic [5:0]                     cur_hour,
    input  logic [5:0]                     cur_date,
    input  logic [2:0]                     cur_wday,
    output logic                           any_en,
    output logic                           all_hit
);

    localparam int unsigned VAL_W = DATA_W - 1;

    logic [FIELD_N-1:0][VAL_W-1:0] cur_vec;
    logic [FIELD_N-1:0]            field_en;
    logic [FIELD_N-1:0]            field_ok;

    assign cur_vec[0] = VAL_W'(cur_min);
    assign cur_vec[1] = VAL_W'(cur_hour);
    assign cur_vec[2] = VAL_W'(cur_date);
    assign cur_vec[3] = VAL_W'(cur_wday);

    for (genvar g = 0; g < FIELD_N; g++) begin : g_cmp
        localparam logic [VAL_W-1:0] MASK = VAL_W'(field_mask(g));
        assign field_en[g] = ~alm_cfg[g][EN_BIT];
        assign field_ok[g] = ~field_en[g] |
                             ((alm_cfg[g][VAL_W-1:0] & MASK) == (cur_vec[g] & MASK));
    end

    assign any_en  = |field_en;
    assign all_hit = &field_ok;

endmodule

// File: rtl/mau_seq.sv
module mau_seq
    import mau_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_sec,
    input  logic [6:0] cur_sec,
    input  logic [6:0] cur_min,
    input  logic       any_en,
    input  logic       all_hit,
    input  logic       clr_req,
    output seq_state_e state,
    output logic       flag
);

    seq_state_e state_nx;
    logic [6:0] held_min;
    logic       sec_zero;
    logic       hit;

    assign sec_zero = (cur_sec == 7'h00);
    assign hit      = (state == ST_CHECK) && any_en && all_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (tick_sec && sec_zero) state_nx = ST_CHECK;          // T_BOUNDARY
            end
            ST_CHECK: begin
                state_nx = hit ? ST_HOLD : ST_IDLE;                    // T_HIT / T_MISS
            end
            ST_HOLD: begin
                if (tick_sec && !sec_zero) begin
                    state_nx = ST_IDLE;                                // T_LEAVE
                end else if (tick_sec && cur_min != held_min) begin
                    state_nx = ST_CHECK;                               // T_REENTER
                end                                                    // else T_REPEAT
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs: status flag and the minute of the last hit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag     <= 1'b0;
            held_min <= '0;
        end else begin
            if (hit) begin
                flag     <= 1'b1;
                held_min <= cur_min;
            end else if (clr_req) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/minute_alarm_unit.sv
module minute_alarm_unit
    import mau_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sec,
    input  logic [6:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [5:0]        cur_hour,
    input  logic [5:0]        cur_date,
    input  logic [2:0]        cur_wday,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);

    logic [FIELD_N-1:0][DATA_W-1:0] alm_cfg;
    logic       alarm_ie;
    logic       alarm_flag;
    logic       clr_req;
    logic       any_field_en;
    logic       all_field_hit;
    seq_state_e seq_state;

    mau_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .flag     (alarm_flag),
        .bus_rdata(bus_rdata),
        .alm_cfg  (alm_cfg),
        .alarm_ie (alarm_ie),
        .clr_req  (clr_req)
    );

    mau_match #(.DATA_W(DATA_W)) u_match (
        .alm_cfg (alm_cfg),
        .cur_min (cur_min),
        .cur_hour(cur_hour),
        .cur_date(cur_date),
        .cur_wday(cur_wday),
        .any_en  (any_field_en),
        .all_hit (all_field_hit)
    );

    mau_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_sec(tick_sec),
        .cur_sec (cur_sec),
        .cur_min (cur_min),
        .any_en  (any_field_en),
        .all_hit (all_field_hit),
        .clr_req (clr_req),
        .state   (seq_state),
        .flag    (alarm_flag)
    );

    always_comb begin
        alarm_irq = alarm_flag & alarm_ie;
    end

endmodule

// File: rtl/mau_checker.sv
module mau_checker
    import mau_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input seq_state_e        state,
    input logic              flag,
    input logic              aie,
    input logic              any_en,
    input logic              alarm_irq
);

    logic st_wr;
    assign st_wr = bus_wr && (bus_addr == ADDR_W'(REG_CTRL_ST));

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !aie |-> !alarm_irq);

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> flag);

    p_clear_on_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !bus_wdata[FLAG_BIT] && state != ST_CHECK) |=> !flag);

    p_write_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && bus_wdata[FLAG_BIT] && state != ST_CHECK) |=> $stable(flag));

    p_set_only_from_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(state == ST_CHECK));

    p_no_set_when_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(any_en));

    p_hold_after_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> state == ST_HOLD);

    p_legal_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_IDLE, ST_CHECK, ST_HOLD});

endmodule

bind minute_alarm_unit mau_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .state    (seq_state),
    .flag     (alarm_flag),
    .aie      (alarm_ie),
    .any_en   (any_field_en),
    .alarm_irq(alarm_irq)
);

// File: tb/test_minute_alarm_unit.sv
module test_minute_alarm_unit;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_sec = 1'b0;
    logic [6:0]        cur_sec = '0;
    logic [6:0]        cur_min = '0;
    logic [5:0]        cur_hour = '0;
    logic [5:0]        cur_date = '0;
    logic [2:0]        cur_wday = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              alarm_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t sb[$];
    event sample_ev;

    always #2 clk = ~clk;

    minute_alarm_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_minute_alarm_unit (
        .clk, .rst_n, .tick_sec, .cur_sec, .cur_min, .cur_hour, .cur_date,
        .cur_wday, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .alarm_irq
    );

    // monitor: pops one expectation per sample event and compares
    always begin
        @(sample_ev);
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (bus_rdata !== e.data || alarm_irq !== e.irq) begin
                n_bad++;
                $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                         e.tag, bus_rdata, alarm_irq, e.data, e.irq);
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] d,
                             input logic irq, input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        e.data = d; e.irq = irq; e.tag = tag;
        sb.push_back(e);
        #1 ->sample_ev;
        #0.5;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                        input logic [5:0] dt, input logic [2:0] wd);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = dt; cur_wday = wd;
        tick_sec = 1'b1;
        @(negedge clk);
        tick_sec = 1'b0;
        @(negedge clk);
    endtask

    task automatic boundary(input logic [6:0] m, input logic [5:0] h,
                            input logic [5:0] dt, input logic [2:0] wd);
        tick(7'h01, m, h, dt, wd);
        tick(7'h00, m, h, dt, wd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(8'h0A, 8'h80, 1'b0, "R1 minute reset");
        expect_rd(8'h0B, 8'h80, 1'b0, "R1 hour reset");
        expect_rd(8'h0C, 8'h80, 1'b0, "R1 date reset");
        expect_rd(8'h0D, 8'h80, 1'b0, "R1 weekday reset");
        expect_rd(8'h00, 8'h00, 1'b0, "R1 enable reset");
        expect_rd(8'h01, 8'h00, 1'b0, "R1 flag reset");

        // R2 storage widths
        wr(8'h0A, 8'hFF); expect_rd(8'h0A, 8'hFF, 1'b0, "R2 minute bits");
        wr(8'h0B, 8'hFF); expect_rd(8'h0B, 8'hBF, 1'b0, "R2 hour bits");
        wr(8'h0C, 8'hFF); expect_rd(8'h0C, 8'hBF, 1'b0, "R2 date bits");
        wr(8'h0D, 8'hFF); expect_rd(8'h0D, 8'h87, 1'b0, "R2 weekday bits");
        wr(8'h00, 8'hFF); expect_rd(8'h00, 8'h02, 1'b0, "R2 enable only bit 1");
        wr(8'h00, 8'h00);
        for (int i = 0; i < 4; i++) wr(8'(8'h0A + i), 8'h80);

        // R9 unmapped address
        wr(8'h05, 8'h55); expect_rd(8'h05, 8'h00, 1'b0, "R9 unmapped read");
        expect_rd(8'h0A, 8'h80, 1'b0, "R9 minute untouched");

        // R5 all fields disabled
        boundary(7'h00, 6'h00, 6'h00, 3'h0);
        expect_rd(8'h01, 8'h00, 1'b0, "R5 all disabled no flag");

        // R4 minute-only alarm, seconds gate
        wr(8'h0A, 8'h30); wr(8'h00, 8'h02);
        tick(7'h05, 7'h30, 6'h12, 6'h01, 3'h2);
        expect_rd(8'h01, 8'h00, 1'b0, "R4 nonzero seconds no flag");
        tick(7'h00, 7'h30, 6'h12, 6'h01, 3'h2);
        expect_rd(8'h01, 8'h08, 1'b1, "R4 minute hit sets flag");

        // R7 acknowledge
        wr(8'h01, 8'h08); expect_rd(8'h01, 8'h08, 1'b1, "R7 write one keeps");
        wr(8'h01, 8'h00); expect_rd(8'h01, 8'h00, 1'b0, "R7 write zero clears");

        // R6 repeated boundary in same minute
        tick(7'h00, 7'h30, 6'h12, 6'h01, 3'h2);
        expect_rd(8'h01, 8'h00, 1'b0, "R6 same minute no refire");
        boundary(7'h30, 6'h12, 6'h01, 3'h2);
        expect_rd(8'h01, 8'h08, 1'b1, "R6 rearmed after nonzero second");
        wr(8'h01, 8'h00);

        // R3 minute and hour
        wr(8'h0B, 8'h12);
        boundary(7'h30, 6'h13, 6'h01, 3'h2);
        expect_rd(8'h01, 8'h00, 1'b0, "R3 hour mismatch");
        boundary(7'h30, 6'h12, 6'h01, 3'h2);
        expect_rd(8'h01, 8'h08, 1'b1, "R3 minute+hour hit");
        wr(8'h01, 8'h00);

        // R8 weekday-only with enable off, then on
        wr(8'h0A, 8'h80); wr(8'h0B, 8'h80); wr(8'h0D, 8'h03); wr(8'h00, 8'h00);
        boundary(7'h45, 6'h07, 6'h09, 3'h3);
        expect_rd(8'h01, 8'h08, 1'b0, "R8 flag set irq masked");
        wr(8'h00, 8'h02);
        expect_rd(8'h01, 8'h08, 1'b1, "R8 irq level after enable");
        wr(8'h01, 8'h00);
        expect_rd(8'h01, 8'h00, 1'b0, "R8 irq drops on clear");

        // R3 date with weekday
        wr(8'h0C, 8'h15);
        boundary(7'h46, 6'h07, 6'h15, 3'h4);
        expect_rd(8'h01, 8'h00, 1'b0, "R3 weekday mismatch");
        boundary(7'h47, 6'h07, 6'h15, 3'h3);
        expect_rd(8'h01, 8'h08, 1'b1, "R3 date+weekday hit");

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule